// File: doc/BRIEF.md
# I2C Controller Register and Queue Front-End

This block is the register side of an I2C master that works from command words. A simple 32-bit register bus with word addressing reaches a set of registers. Word 0 is one location for two queues: a write there puts a 10-bit command into a transmit queue, and a read there takes the oldest byte out of a receive queue. The other words hold these registers:

- a status word;
- an interrupt-enable and soft-reset control word;
- two SCL divider registers;
- the own-address register;
- the level of each queue;
- a running count of bytes received and a running count of bytes sent.

The serial bit engine sits behind two valid/ready streams. The command stream (`cmd_*`) leaves the transmit queue. A beat moves only on a clock edge where both `cmd_valid` and `cmd_ready` are high. While `cmd_valid` is high and `cmd_ready` is low, `cmd_data` holds its value. The engine can stall the stream for any number of cycles.

The receive stream (`rx_*`) fills the receive queue. `rx_ready` drops while that queue is full or a soft reset is running. The engine must then hold its byte until `rx_ready` returns.

Event and line levels from the engine become status bits. Each status condition is masked by its own enable bit, and the results are combined into one interrupt line. A self-clearing soft reset empties both queues and clears the byte counters. The same reset is driven out to the engine.

Top module: `i2c_mmio_front`

## Requirements
- R1: A bus write to word 0 places `bus_wdata[9:0]` in the transmit queue. The queue entries leave on `cmd_data` in the order they were written. A beat is taken on each edge where `cmd_valid` and `cmd_ready` are both high. While the consumer stalls, `cmd_data` stays stable.
- R2: A bus read of word 0 removes the oldest received byte and returns it in `bus_rdata[7:0]`, with the upper bits zero. If the receive queue is empty, the read returns 0 and changes nothing.
- R3: Each queue holds DEPTH (4) entries. A write to a full transmit queue is discarded. `rx_ready` is low while the receive queue is full.
- R4: Status (word 1) bit positions:
  - 0: done flag;
  - 1: arbitration-lost flag;
  - 2: `eng_nack`;
  - 3: `eng_need_data`;
  - 5: `eng_active`;
  - 6: `scl_in`;
  - 7: `sda_in`;
  - 8: receive full;
  - 9: receive empty;
  - 10: transmit full;
  - 11: transmit empty.

  All other bits read 0.
- R5: A pulse on `eng_done` sets the done flag, and a pulse on `eng_arb_lost` sets the arbitration flag. Each flag stays set until software writes 1 to its status bit. Writing 0 to these bits has no effect.
- R6: Control (word 2) bits 7..0 are interrupt enables. They can be written and read back. `irq` is high while any enabled condition is true. The conditions by enable bit are:
  - 0: done;
  - 1: arbitration lost;
  - 2: no-ack;
  - 3: need-data;
  - 4: slave data, which has no source here;
  - 5: receive full;
  - 6: receive not empty;
  - 7: transmit full.
- R7: Writing 1 to control bit 8 starts a soft reset. Bit 8 then reads 1, and `soft_rst` is high, for RST_CYCLES cycles; after that it clears by itself. The reset empties both queues, so status bits 9 and 11 read 1. It also zeroes both byte counters.
- R8: The SCL-low divider (word 3, 10 bits), the SCL-high divider (word 4, 10 bits) and the own address (word 5, 7 bits) read back as written, with the upper bits masked. They drive `scl_lo_div`, `scl_hi_div` and `own_addr`.
- R9: Word 6 reads the receive-queue level and word 7 reads the transmit-queue level.
- R10: Word 8 counts bytes accepted on the receive stream. Word 9 counts commands accepted by the engine on the command stream.
- R11: A read returns its data on `bus_rdata`, with `bus_rvalid` high, in the cycle after the request.
- R12: The receive-data interrupt (enable bit 6) is asserted while the receive queue holds at least one byte, and drops when the queue empties.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_waddr | input | 4 | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Read data |
| cmd_valid | output | 1 | Command stream valid |
| cmd_ready | input | 1 | Command stream ready from engine |
| cmd_data | output | 10 | Command word |
| rx_valid | input | 1 | Received byte valid |
| rx_ready | output | 1 | Receive queue can accept |
| rx_data | input | 8 | Received byte |
| eng_done | input | 1 | Transfer-done pulse |
| eng_arb_lost | input | 1 | Arbitration-lost pulse |
| eng_nack | input | 1 | No-acknowledge level |
| eng_need_data | input | 1 | Engine waiting for a command |
| eng_active | input | 1 | Bus busy level |
| scl_in | input | 1 | Sampled SCL line |
| sda_in | input | 1 | Sampled SDA line |
| scl_lo_div | output | 10 | SCL low-phase divider |
| scl_hi_div | output | 10 | SCL high-phase divider |
| own_addr | output | 7 | Own bus address |
| soft_rst | output | 1 | Soft reset in progress |
| irq | output | 1 | Combined interrupt |

## Verification
Timing of each result, counted in clock edges after the stimulus:

- **Register writes:** their effects (queue levels, flags, enables, divider outputs, flush) appear one edge after the request edge.
- **Register reads:** data appears on `bus_rdata` one edge after the request.
- **`irq`:** it is combinational from that state, so it follows in the same cycle.
- **Soft-reset bit:** it stays set for RST_CYCLES edges after the write edge.
- **Stream handshakes:** they complete on the edge where valid and ready are both seen.

The bench drives all inputs and samples all outputs on falling edges. Each bus task therefore samples half a cycle after the edge that produced the result. The stream handshake is judged from `cmd_valid`, `cmd_ready` and `rx_ready` as they are visible just before the edge that completes it.

// File: rtl/i2c_front_pkg.sv
package i2c_front_pkg;
  // register word indices
  localparam logic [3:0] W_QUEUE = 4'd0;
  localparam logic [3:0] W_STAT  = 4'd1;
  localparam logic [3:0] W_CTRL  = 4'd2;
  localparam logic [3:0] W_SCLLO = 4'd3;
  localparam logic [3:0] W_SCLHI = 4'd4;
  localparam logic [3:0] W_OWN   = 4'd5;
  localparam logic [3:0] W_RXLVL = 4'd6;
  localparam logic [3:0] W_TXLVL = 4'd7;
  localparam logic [3:0] W_RXCNT = 4'd8;
  localparam logic [3:0] W_TXCNT = 4'd9;

  // status bit positions
  localparam int S_DONE  = 0;
  localparam int S_ARB   = 1;
  localparam int S_NACK  = 2;
  localparam int S_NEED  = 3;
  localparam int S_ACT   = 5;
  localparam int S_SCL   = 6;
  localparam int S_SDA   = 7;
  localparam int S_RXFUL = 8;
  localparam int S_RXEMP = 9;
  localparam int S_TXFUL = 10;
  localparam int S_TXEMP = 11;

  // control layout
  localparam int N_IRQ   = 8;
  localparam int C_SRST  = 8;
endpackage

// File: rtl/i2c_front_fifo.sv
module i2c_front_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic                       full,
  output logic                       empty,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] cnt;
  logic          push_ok, pop_ok;

  assign full    = (cnt == LW'(DEPTH));
  assign empty   = (cnt == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rd_ptr];
  assign level   = cnt;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_ok) wr_ptr <= nxt(wr_ptr);
      if (pop_ok)  rd_ptr <= nxt(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LW'(DEPTH));
  assert_full_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> full);
  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
endmodule

// File: rtl/i2c_front_rstseq.sv
module i2c_front_rstseq #(
  parameter int CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYCLES+1);
  logic [CW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      left <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        left <= CW'(CYCLES-1);
      end
    end else if (left == '0) begin
      busy <= 1'b0;
    end else begin
      left <= left - 1'b1;
    end
  end

  assert_no_spontaneous_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy);
  assert_start_takes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);
endmodule

// File: rtl/i2c_front_irq.sv
module i2c_front_irq #(
  parameter int N = 8
) (
  input  logic [N-1:0] cond,
  input  logic [N-1:0] en,
  output logic         irq
);
  logic [N-1:0] hit;
  for (genvar i = 0; i < N; i++) begin : g_mask
    assign hit[i] = cond[i] & en[i];
  end
  assign irq = |hit;
endmodule

// File: rtl/i2c_mmio_front.sv
module i2c_mmio_front
  import i2c_front_pkg::*;
#(
  parameter int DEPTH      = 4,
  parameter int CMD_W      = 10,
  parameter int DATA_W     = 8,
  parameter int DIV_W      = 10,
  parameter int OWN_W      = 7,
  parameter int CNT_W      = 16,
  parameter int RST_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [3:0]        bus_waddr,
  input  logic [31:0]       bus_wdata,
  output logic              bus_rvalid,
  output logic [31:0]       bus_rdata,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [CMD_W-1:0]  cmd_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              eng_done,
  input  logic              eng_arb_lost,
  input  logic              eng_nack,
  input  logic              eng_need_data,
  input  logic              eng_active,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic [DIV_W-1:0]  scl_lo_div,
  output logic [DIV_W-1:0]  scl_hi_div,
  output logic [OWN_W-1:0]  own_addr,
  output logic              soft_rst,
  output logic              irq
);
  localparam int LW = $clog2(DEPTH+1);

  logic wr_hit, rd_hit;
  logic w_queue, w_stat, w_ctrl, r_queue;
  logic rst_start, rst_busy, flush;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic [LW-1:0] tx_lvl, rx_lvl;
  logic [DATA_W-1:0] rx_head;
  logic tx_pop, rx_push;
  logic done_q, arb_q;
  logic [N_IRQ-1:0] ctrl_en, irq_cond;
  logic [DIV_W-1:0] lo_q, hi_q;
  logic [OWN_W-1:0] own_q;
  logic [CNT_W-1:0] rxcnt_q, txcnt_q;
  logic [31:0] stat_w, rd_mux;
  logic unused_wbits;

  assign unused_wbits = ^bus_wdata[31:C_SRST+1];

  assign wr_hit  = bus_req && bus_we;
  assign rd_hit  = bus_req && !bus_we;
  assign w_queue = wr_hit && (bus_waddr == W_QUEUE);
  assign w_stat  = wr_hit && (bus_waddr == W_STAT);
  assign w_ctrl  = wr_hit && (bus_waddr == W_CTRL);
  assign r_queue = rd_hit && (bus_waddr == W_QUEUE);

  // soft reset sequencer
  assign rst_start = w_ctrl && bus_wdata[C_SRST];
  assign flush     = rst_start || rst_busy;
  assign soft_rst  = rst_busy;

  i2c_front_rstseq #(.CYCLES(RST_CYCLES)) i_rstseq (
    .clk(clk), .rst_n(rst_n), .start(rst_start), .busy(rst_busy)
  );

  // transmit queue and command stream
  assign cmd_valid = !tx_empty && !rst_busy;
  assign tx_pop    = cmd_valid && cmd_ready;

  i2c_front_fifo #(.W(CMD_W), .DEPTH(DEPTH)) i_txq (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(w_queue), .din(bus_wdata[CMD_W-1:0]),
    .pop(tx_pop), .dout(cmd_data),
    .full(tx_full), .empty(tx_empty), .level(tx_lvl)
  );

  // receive queue and byte stream
  assign rx_ready = !rx_full && !rst_busy;
  assign rx_push  = rx_valid && rx_ready;

  i2c_front_fifo #(.W(DATA_W), .DEPTH(DEPTH)) i_rxq (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(rx_push), .din(rx_data),
    .pop(r_queue), .dout(rx_head),
    .full(rx_full), .empty(rx_empty), .level(rx_lvl)
  );

  // sticky event flags, write-one-to-clear, set wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      arb_q  <= 1'b0;
    end else begin
      if (eng_done)                              done_q <= 1'b1;
      else if (w_stat && bus_wdata[S_DONE])      done_q <= 1'b0;
      if (eng_arb_lost)                          arb_q  <= 1'b1;
      else if (w_stat && bus_wdata[S_ARB])       arb_q  <= 1'b0;
    end
  end

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      own_q   <= '0;
    end else if (wr_hit) begin
      case (bus_waddr)
        W_CTRL:  ctrl_en <= bus_wdata[N_IRQ-1:0];
        W_SCLLO: lo_q    <= bus_wdata[DIV_W-1:0];
        W_SCLHI: hi_q    <= bus_wdata[DIV_W-1:0];
        W_OWN:   own_q   <= bus_wdata[OWN_W-1:0];
        default: ;
      endcase
    end
  end

  assign scl_lo_div = lo_q;
  assign scl_hi_div = hi_q;
  assign own_addr   = own_q;

  // byte counters
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxcnt_q <= '0;
      txcnt_q <= '0;
    end else if (flush) begin
      rxcnt_q <= '0;
      txcnt_q <= '0;
    end else begin
      if (rx_push) rxcnt_q <= rxcnt_q + 1'b1;
      if (tx_pop)  txcnt_q <= txcnt_q + 1'b1;
    end
  end

  // status word
  always_comb begin
    stat_w          = '0;
    stat_w[S_DONE]  = done_q;
    stat_w[S_ARB]   = arb_q;
    stat_w[S_NACK]  = eng_nack;
    stat_w[S_NEED]  = eng_need_data;
    stat_w[S_ACT]   = eng_active;
    stat_w[S_SCL]   = scl_in;
    stat_w[S_SDA]   = sda_in;
    stat_w[S_RXFUL] = rx_full;
    stat_w[S_RXEMP] = rx_empty;
    stat_w[S_TXFUL] = tx_full;
    stat_w[S_TXEMP] = tx_empty;
  end

  // interrupt combiner
  assign irq_cond = {tx_full, !rx_empty, rx_full, 1'b0,
                     eng_need_data, eng_nack, arb_q, done_q};

  i2c_front_irq #(.N(N_IRQ)) i_irq (
    .cond(irq_cond), .en(ctrl_en), .irq(irq)
  );

  // read path
  always_comb begin
    case (bus_waddr)
      W_QUEUE: rd_mux = rx_empty ? '0 : 32'(rx_head);
      W_STAT:  rd_mux = stat_w;
      W_CTRL:  rd_mux = 32'({rst_busy, ctrl_en});
      W_SCLLO: rd_mux = 32'(lo_q);
      W_SCLHI: rd_mux = 32'(hi_q);
      W_OWN:   rd_mux = 32'(own_q);
      W_RXLVL: rd_mux = 32'(rx_lvl);
      W_TXLVL: rd_mux = 32'(tx_lvl);
      W_RXCNT: rd_mux = 32'(rxcnt_q);
      W_TXCNT: rd_mux = 32'(txcnt_q);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd_hit;
      if (rd_hit) bus_rdata <= rd_mux;
    end
  end

  assert_cmd_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && !rst_start) |=> (cmd_valid && $stable(cmd_data)));
  assert_empty_read_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (r_queue && rx_empty) |=> (bus_rdata == '0));
  assert_done_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !(w_stat && bus_wdata[S_DONE])) |=> done_q);
  assert_done_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (w_stat && bus_wdata[S_DONE] && !eng_done) |=> !done_q);
  assert_irq_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en == '0) |-> !irq);
  assert_rvalid_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> bus_rvalid);
endmodule

// File: tb/test_i2c_mmio_front.sv
`timescale 1ns/1ps
module test_i2c_mmio_front;
  localparam int DEPTH = 4;
  localparam int RSTC  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_req = 0, bus_we = 0;
  logic [3:0] bus_waddr = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_rvalid;
  logic [31:0] bus_rdata;
  logic cmd_valid, cmd_ready = 0;
  logic [9:0] cmd_data;
  logic rx_valid = 0, rx_ready;
  logic [7:0] rx_data = '0;
  logic eng_done = 0, eng_arb_lost = 0, eng_nack = 0, eng_need_data = 0;
  logic eng_active = 0, scl_in = 0, sda_in = 0;
  logic [9:0] scl_lo_div, scl_hi_div;
  logic [6:0] own_addr;
  logic soft_rst, irq;

  int n_chk = 0, n_fail = 0;
  logic [9:0] txq[$];
  logic [7:0] rxq[$];
  int txcnt = 0, rxcnt = 0;

  always #2.5 clk = ~clk;

  i2c_mmio_front #(.DEPTH(DEPTH), .RST_CYCLES(RSTC)) i_i2c_mmio_front (
    .clk(clk), .rst_n(rst_n),
    .bus_req(bus_req), .bus_we(bus_we), .bus_waddr(bus_waddr),
    .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .eng_done(eng_done), .eng_arb_lost(eng_arb_lost), .eng_nack(eng_nack),
    .eng_need_data(eng_need_data), .eng_active(eng_active),
    .scl_in(scl_in), .sda_in(sda_in),
    .scl_lo_div(scl_lo_div), .scl_hi_div(scl_hi_div), .own_addr(own_addr),
    .soft_rst(soft_rst), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // status word from the R4 bit layout
  function automatic logic [31:0] exp_stat(input logic done, input logic arb);
    logic [31:0] s = '0;
    s[0]  = done;          s[1]  = arb;
    s[2]  = eng_nack;      s[3]  = eng_need_data;
    s[5]  = eng_active;    s[6]  = scl_in;  s[7] = sda_in;
    s[8]  = (rxq.size() == DEPTH);  s[9]  = (rxq.size() == 0);
    s[10] = (txq.size() == DEPTH);  s[11] = (txq.size() == 0);
    return s;
  endfunction

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_waddr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 0; bus_we = 0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = 0; bus_waddr = a;
    @(negedge clk);
    d = bus_rdata;
    chk("R11 rvalid", {31'd0, bus_rvalid}, 32'd1);
    bus_req = 0;
  endtask

  task automatic tx_write(input logic [9:0] c);
    bus_write(4'd0, {22'h3FFFFF, c});
    if (txq.size() < DEPTH) txq.push_back(c);
  endtask

  task automatic rx_send(input logic [7:0] b);
    logic acc;
    @(negedge clk);
    rx_valid = 1; rx_data = b;
    #1 acc = rx_ready;
    chk("R3 rx_ready vs level", {31'd0, acc}, {31'd0, rxq.size() < DEPTH});
    if (acc) begin rxq.push_back(b); rxcnt++; end
    @(posedge clk); #1 rx_valid = 0;
  endtask

  task automatic drain_tx();
    logic stall = 0;
    logic [9:0] held = '0;
    for (int c = 0; c < 300 && txq.size() > 0; c++) begin
      @(negedge clk);
      cmd_ready = ($urandom % 3) != 0;
      #1;
      if (stall) chk("R1 data held under stall", {22'd0, cmd_data}, {22'd0, held});
      if (cmd_valid && cmd_ready) begin
        chk("R1 command order", {22'd0, cmd_data}, {22'd0, txq[0]});
        void'(txq.pop_front()); txcnt++;
        stall = 0;
      end else begin
        stall = cmd_valid; held = cmd_data;
      end
    end
    @(negedge clk); cmd_ready = 0;
    chk("R1 queue drained", {31'd0, cmd_valid}, 32'd0);
  endtask

  task automatic read_rx(input int n);
    logic [31:0] d;
    for (int i = 0; i < n; i++) begin
      bus_read(4'd0, d);
      if (rxq.size() > 0) begin
        chk("R2 receive byte order", d, {24'd0, rxq[0]});
        void'(rxq.pop_front());
      end else chk("R2 empty read returns 0", d, 32'd0);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    int polls;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // reset state
    @(negedge clk);
    chk("R1 cmd_valid after reset", {31'd0, cmd_valid}, 32'd0);
    chk("R6 irq after reset", {31'd0, irq}, 32'd0);
    bus_read(4'd1, d); chk("R4 status after reset", d, 32'h0000_0A00);
    bus_read(4'd2, d); chk("R6 control after reset", d, 32'd0);

    // line levels and engine levels in status
    eng_active = 1; scl_in = 1; sda_in = 1; eng_need_data = 1;
    bus_read(4'd1, d); chk("R4 status levels", d, exp_stat(0, 0));
    eng_active = 0; scl_in = 0; sda_in = 0; eng_need_data = 0;

    // divider and address registers
    bus_write(4'd3, 32'hFFFF_F2A5);
    bus_write(4'd4, 32'h0000_0123);
    bus_write(4'd5, 32'hFFFF_FFD3);
    bus_read(4'd3, d); chk("R8 scl low readback", d, 32'h2A5);
    bus_read(4'd4, d); chk("R8 scl high readback", d, 32'h123);
    bus_read(4'd5, d); chk("R8 own address readback", d, 32'h53);
    chk("R8 scl_lo_div pin", {22'd0, scl_lo_div}, 32'h2A5);
    chk("R8 scl_hi_div pin", {22'd0, scl_hi_div}, 32'h123);
    chk("R8 own_addr pin", {25'd0, own_addr}, 32'h53);

    // directed: overfill transmit queue
    for (int i = 0; i < 5; i++) tx_write(10'(10'h100 + i));
    bus_read(4'd7, d); chk("R9 tx level full", d, DEPTH);
    bus_read(4'd1, d); chk("R3 status tx full", d, exp_stat(0, 0));
    drain_tx();
    bus_read(4'd9, d); chk("R10 tx byte count", d, txcnt);

    // directed: overfill receive queue
    for (int i = 0; i < 5; i++) rx_send(8'(8'hA0 + i));
    bus_read(4'd6, d); chk("R9 rx level full", d, DEPTH);
    bus_read(4'd1, d); chk("R4 status rx full", d, exp_stat(0, 0));
    read_rx(5);
    bus_read(4'd6, d); chk("R2 level stays 0 after empty read", d, 0);
    bus_read(4'd8, d); chk("R10 rx byte count", d, rxcnt);

    // receive-data interrupt
    bus_write(4'd2, 32'h40);
    @(negedge clk); chk("R12 irq low while empty", {31'd0, irq}, 32'd0);
    rx_send(8'h5C);
    @(negedge clk); chk("R12 irq with data", {31'd0, irq}, 32'd1);
    bus_write(4'd2, 32'h00);
    @(negedge clk); chk("R6 irq masked", {31'd0, irq}, 32'd0);
    bus_write(4'd2, 32'h40);
    read_rx(1);
    @(negedge clk); chk("R12 irq drops when emptied", {31'd0, irq}, 32'd0);

    // done flag: sticky, w1c, writing 0 ignored
    bus_write(4'd2, 32'h01);
    @(negedge clk); eng_done = 1; @(negedge clk); eng_done = 0;
    chk("R6 irq on done", {31'd0, irq}, 32'd1);
    bus_write(4'd1, 32'h0);
    bus_read(4'd1, d); chk("R5 done kept on write 0", d, exp_stat(1, 0));
    bus_write(4'd1, 32'h1);
    bus_read(4'd1, d); chk("R5 done cleared by write 1", d, exp_stat(0, 0));
    chk("R5 irq after clear", {31'd0, irq}, 32'd0);

    // arbitration flag
    bus_write(4'd2, 32'h02);
    @(negedge clk); eng_arb_lost = 1; @(negedge clk); eng_arb_lost = 0;
    chk("R6 irq on arbitration", {31'd0, irq}, 32'd1);
    bus_write(4'd1, 32'h1);
    bus_read(4'd1, d); chk("R5 arb kept when only bit0 written", d, exp_stat(0, 1));
    bus_write(4'd1, 32'h2);
    bus_read(4'd1, d); chk("R5 arb cleared", d, exp_stat(0, 0));

    // no-ack level and transmit-full condition
    bus_write(4'd2, 32'h84);
    eng_nack = 1;
    @(negedge clk); chk("R6 irq on no-ack", {31'd0, irq}, 32'd1);
    eng_nack = 0;
    @(negedge clk); chk("R6 irq follows no-ack", {31'd0, irq}, 32'd0);
    for (int i = 0; i < DEPTH; i++) tx_write(10'(10'h2F0 + i));
    @(negedge clk); chk("R6 irq on tx full", {31'd0, irq}, 32'd1);
    bus_read(4'd2, d); chk("R6 control readback", d, 32'h84);

    // soft reset
    rx_send(8'h11); rx_send(8'h22);
    bus_write(4'd2, 32'h100);
    txq.delete(); rxq.delete(); txcnt = 0; rxcnt = 0;
    chk("R7 soft_rst pin high", {31'd0, soft_rst}, 32'd1);
    bus_read(4'd2, d); chk("R7 reset bit reads 1", d, 32'h100);
    polls = 0;
    while (d[8] && polls < 50) begin bus_read(4'd2, d); polls++; end
    chk("R7 reset bit self-clears", d, 32'h0);
    chk("R7 reset within bound", {31'd0, polls <= RSTC}, 32'd1);
    bus_read(4'd1, d); chk("R7 queues empty after reset", d, 32'h0A00);
    bus_read(4'd7, d); chk("R7 tx level 0", d, 0);
    bus_read(4'd6, d); chk("R7 rx level 0", d, 0);
    bus_read(4'd8, d); chk("R7 rx count cleared", d, 0);
    bus_read(4'd9, d); chk("R7 tx count cleared", d, 0);

    // constrained random rounds
    for (int r = 0; r < 6; r++) begin
      int n;
      n = 1 + int'($urandom % 6);
      for (int i = 0; i < n; i++) tx_write(10'($urandom));
      bus_read(4'd7, d); chk("R9 tx level random", d, txq.size());
      drain_tx();
      bus_read(4'd9, d); chk("R10 tx count random", d, txcnt);
      n = 1 + int'($urandom % 6);
      for (int i = 0; i < n; i++) rx_send(8'($urandom));
      bus_read(4'd6, d); chk("R9 rx level random", d, rxq.size());
      read_rx(int'($urandom % 7));
      bus_read(4'd1, d); chk("R4 status random", d, exp_stat(0, 0));
      bus_read(4'd8, d); chk("R10 rx count random", d, rxcnt);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule